// File: doc/BRIEF.md
# Address-Quadrant Wait-State Ready Generator

This block produces the ready handshake for a processor bus. An access begins when any of the four access strobes (memory read, memory write, I/O read, I/O write) goes active. The block then holds ready low for a number of wait states and finally raises ready for exactly one clock. The wait count comes from a 4-bit field chosen by the top two address bits, so each quarter of the 16-bit address space has its own count. Memory and I/O accesses each have a separate 16-bit register holding four such fields.

A long-ready mode can be switched on separately for memory accesses in the lowest quarter and for I/O accesses in two 256-address windows (0000-00FF and 8000-80FF). In that mode the field gives a delay in milliseconds, not cycles. The millisecond is timed by counting (programmed clock frequency in MHz) × 1000 clock cycles. A control bit can widen ordinary I/O wait-state insertion to the whole I/O space. Otherwise, I/O accesses outside the two windows complete with no wait states. All settings are loaded through a simple synchronous register write port.

Top module: `qws_ready_gen`

## Requirements
- R1: Synchronous reset with active-low `rst_n` drives `ready` low, sets the memory wait register to FFFF (15 waits in every quarter) and clears the control register. The I/O wait register has no reset value.
- R2: A memory access in quarter q (q = addr[15:14]) waits for the memory field in bits 4q+3:4q. If the strobes are first seen active at clock edge E0 and the field is N, then `ready` is high in the cycle after edge E0+N.
- R3: An I/O access with addr[14:8] = 0 (windows 0000-00FF and 8000-80FF) waits for the I/O field of its quarter, with the timing of R2.
- R4: An I/O access outside those windows completes with zero waits while the extend bit is 0. When the extend bit is 1, it waits for the I/O field of its quarter.
- R5: `ready` is high for one cycle per access. No further pulse comes until every strobe has been low and a new access starts.
- R6: With the long-memory bit set, a memory access in 0000-3FFF waits field × F × 1000 cycles, where F is the frequency field. Memory accesses in other quarters keep cycle-count waits.
- R7: With the long-I/O bit set, an I/O access inside the windows of R3 waits field × F × 1000 cycles. I/O accesses outside the windows follow R4.
- R8: A field value of 0 gives zero waits in both cycle and long modes. A frequency field of 0 is treated as 1 MHz.
- R9: If every strobe goes low before `ready` is given, the access is dropped and no `ready` pulse follows.
- R10: When memory and I/O strobes are active together, the memory wait field applies.
- R11: A register write with `cfg_we` high loads `cfg_wdata` into the register chosen by `cfg_sel`. Select 0 is control: bits 5:0 frequency in MHz, bit 8 I/O extend, bit 9 long-I/O enable, bit 10 long-memory enable. Select 1 is the memory waits and select 2 is the I/O waits. Select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select (0 control, 1 memory waits, 2 I/O waits) |
| cfg_wdata | input | 16 | Register write data |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| addr | input | 16 | Access address |
| ready | output | 1 | One-cycle ready pulse ending the wait |

## Verification
Memory accesses are swept over every quarter, at its lowest, middle and highest address, under two wait patterns that give each quarter a different count. A fault in quarter decoding or field slicing therefore shows up as a wrong wait count. I/O accesses go to window edges, to addresses just outside the windows and to every quarter, with the extend bit both clear and set. This separates the window test from the quarter choice. Long-mode runs use several frequency values, including 0, together with addresses just outside each eligible range. These runs tell the millisecond scaling apart from cycle waits. Abandoned accesses and combined memory-plus-I/O strobes cover the dropped-access and priority rules.

// File: rtl/qws_pkg.sv
// Shared types and control-field positions for the ready generator.
// Assumes a 16-bit register write port and a 6-bit frequency field.
package qws_pkg;

    localparam int FREQ_W       = 6;
    localparam int CTL_EXT_BIT  = 8;
    localparam int CTL_LIO_BIT  = 9;
    localparam int CTL_LMEM_BIT = 10;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_MEM  = 2'd1;
    localparam logic [1:0] SEL_IO   = 2'd2;

    typedef enum logic [1:0] {
        MODE_ZERO,
        MODE_CYCLES,
        MODE_LONG
    } wait_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CYC,
        ST_LONG,
        ST_DONE
    } tmr_state_e;

    typedef struct packed {
        logic              long_mem;
        logic              long_io;
        logic              io_extend;
        logic [FREQ_W-1:0] freq_mhz;
    } ctrl_t;

endpackage

// File: rtl/qws_cfg_regs.sv
// Configuration registers: control, memory waits, I/O waits.
// Assumes the write data width equals four wait fields. The I/O
// wait register is deliberately left without a reset value.
module qws_cfg_regs
    import qws_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] mem_ws,
    output logic [REG_W-1:0] io_ws
);

    // Control and memory-wait registers with defined reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            mem_ws <= '1;
        end else if (we) begin
            if (sel == SEL_CTRL) begin
                ctrl.freq_mhz  <= wdata[FREQ_W-1:0];
                ctrl.io_extend <= wdata[CTL_EXT_BIT];
                ctrl.long_io   <= wdata[CTL_LIO_BIT];
                ctrl.long_mem  <= wdata[CTL_LMEM_BIT];
            end
            if (sel == SEL_MEM) begin
                mem_ws <= wdata;
            end
        end
    end

    // I/O-wait register: loaded only by software, never reset.
    always_ff @(posedge clk) begin
        if (we && sel == SEL_IO) begin
            io_ws <= wdata;
        end
    end

    // R11: memory waits change only on a write addressed to them
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_MEM) |=> $stable(mem_ws));

    // R11: control changes only on a write addressed to it
    p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_CTRL) |=> $stable(ctrl));

endmodule

// File: rtl/qws_decode.sv
// Classifies an access: picks the quadrant field and decides whether
// it waits zero cycles, a cycle count, or milliseconds.
// Assumes the quadrant is the top address bits; the window mask marks
// the address bits that must be zero for the long-I/O windows.
module qws_decode
    import qws_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              FIELD_W  = 4,
    parameter int              NQUAD    = 4,
    parameter logic [ADDR_W-1:0] WIN_MASK = 16'h7F00
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     is_mem,
    input  logic                     io_extend,
    input  logic                     long_io,
    input  logic                     long_mem,
    input  logic [NQUAD*FIELD_W-1:0] mem_ws,
    input  logic [NQUAD*FIELD_W-1:0] io_ws,
    output wait_mode_e               mode,
    output logic [FIELD_W-1:0]       count
);

    localparam int QB = $clog2(NQUAD);

    logic [FIELD_W-1:0] mem_f [NQUAD];
    logic [FIELD_W-1:0] io_f  [NQUAD];
    logic [QB-1:0]      quad;
    logic               in_win;

    // Split each wait register into its per-quadrant fields.
    for (genvar q = 0; q < NQUAD; q++) begin : g_field
        assign mem_f[q] = mem_ws[q*FIELD_W +: FIELD_W];
        assign io_f[q]  = io_ws[q*FIELD_W +: FIELD_W];
    end

    assign quad   = addr[ADDR_W-1 -: QB];
    assign in_win = ((addr & WIN_MASK) == '0);

    // Choose the field and the wait mode for the current access.
    always_comb begin
        logic zero_path;
        logic use_long;
        zero_path = 1'b0;
        use_long  = 1'b0;
        if (is_mem) begin
            count    = mem_f[quad];
            use_long = long_mem && (quad == '0);
        end else begin
            count = io_f[quad];
            if (in_win) begin
                use_long = long_io;
            end else if (!io_extend) begin
                zero_path = 1'b1;
            end
        end
        if (zero_path || count == '0) begin
            mode = MODE_ZERO;
        end else if (use_long) begin
            mode = MODE_LONG;
        end else begin
            mode = MODE_CYCLES;
        end
    end

endmodule

// File: rtl/qws_timer.sv
// Wait-state sequencer: counts cycles or millisecond ticks after an
// access starts, then pulses ready for one cycle.
// Assumes start is a one-cycle pulse at the beginning of an access and
// any_strobe stays high for the whole access.
module qws_timer
    import qws_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int KHZ     = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_strobe,
    input  logic               start,
    input  wait_mode_e         mode,
    input  logic [FIELD_W-1:0] count,
    input  logic [FREQ_W-1:0]  freq_mhz,
    output logic               ready
);

    localparam int MAXF  = (1 << FREQ_W) - 1;
    localparam int PRE_W = $clog2(MAXF * KHZ + 1);

    tmr_state_e         state;
    logic [FIELD_W-1:0] cnt;
    logic [PRE_W-1:0]   pre;
    logic [PRE_W-1:0]   eff_f;
    logic [PRE_W-1:0]   pre_len;

    // Cycles per millisecond minus one; a zero frequency counts as 1 MHz.
    always_comb begin
        eff_f   = (freq_mhz == '0) ? PRE_W'(1) : PRE_W'(freq_mhz);
        pre_len = eff_f * PRE_W'(KHZ) - PRE_W'(1);
    end

    // Main sequencer: load counters on start, count down, pulse ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            pre   <= '0;
            ready <= 1'b0;
        end else begin
            ready <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        case (mode)
                            MODE_CYCLES: begin
                                cnt   <= count - FIELD_W'(1);
                                state <= ST_CYC;
                            end
                            MODE_LONG: begin
                                cnt   <= count - FIELD_W'(1);
                                pre   <= pre_len;
                                state <= ST_LONG;
                            end
                            default: begin
                                ready <= 1'b1;
                                state <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_CYC: begin
                    if (!any_strobe) begin
                        state <= ST_IDLE;
                    end else if (cnt == '0) begin
                        ready <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        cnt <= cnt - FIELD_W'(1);
                    end
                end
                ST_LONG: begin
                    if (!any_strobe) begin
                        state <= ST_IDLE;
                    end else if (pre == '0) begin
                        if (cnt == '0) begin
                            ready <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            cnt <= cnt - FIELD_W'(1);
                            pre <= pre_len;
                        end
                    end else begin
                        pre <= pre - PRE_W'(1);
                    end
                end
                default: begin
                    if (!any_strobe) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R5: ready never lasts two cycles
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R5: ready only follows a cycle with an active strobe
    p_ready_in_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(any_strobe));

    // R8: a zero-wait access answers on the next cycle
    p_zero_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && mode == MODE_ZERO) |=> ready);

    // R9: a dropped access returns to idle without a pulse
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CYC || state == ST_LONG) && !any_strobe)
        |=> (!ready && state == ST_IDLE));

endmodule

// File: rtl/qws_ready_gen.sv
// Top of the quadrant wait-state ready generator. Detects the start of
// an access from the four strobes, classifies it and runs the timer.
// Assumes strobes are synchronous to clk and active high; memory
// strobes take priority when both kinds are active.
module qws_ready_gen
    import qws_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int FIELD_W = 4,
    parameter int NQUAD   = 4,
    parameter int KHZ     = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_sel,
    input  logic [NQUAD*FIELD_W-1:0] cfg_wdata,
    input  logic                     mem_rd,
    input  logic                     mem_wr,
    input  logic                     io_rd,
    input  logic                     io_wr,
    input  logic [ADDR_W-1:0]        addr,
    output logic                     ready
);

    localparam int REG_W = NQUAD * FIELD_W;

    ctrl_t              ctrl;
    logic [REG_W-1:0]   mem_ws;
    logic [REG_W-1:0]   io_ws;
    logic               any_strobe;
    logic               any_q;
    logic               start;
    logic               is_mem;
    wait_mode_e         mode;
    logic [FIELD_W-1:0] count;

    assign is_mem     = mem_rd | mem_wr;
    assign any_strobe = is_mem | io_rd | io_wr;
    assign start      = any_strobe & ~any_q;

    // Remember last cycle's strobe state for start detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
        end else begin
            any_q <= any_strobe;
        end
    end

    qws_cfg_regs #(
        .REG_W (REG_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .ctrl   (ctrl),
        .mem_ws (mem_ws),
        .io_ws  (io_ws)
    );

    qws_decode #(
        .ADDR_W  (ADDR_W),
        .FIELD_W (FIELD_W),
        .NQUAD   (NQUAD)
    ) u_dec (
        .addr      (addr),
        .is_mem    (is_mem),
        .io_extend (ctrl.io_extend),
        .long_io   (ctrl.long_io),
        .long_mem  (ctrl.long_mem),
        .mem_ws    (mem_ws),
        .io_ws     (io_ws),
        .mode      (mode),
        .count     (count)
    );

    qws_timer #(
        .FIELD_W (FIELD_W),
        .KHZ     (KHZ)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_strobe (any_strobe),
        .start      (start),
        .mode       (mode),
        .count      (count),
        .freq_mhz   (ctrl.freq_mhz),
        .ready      (ready)
    );

    // R1: ready stays low in the cycle after a reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !ready);

endmodule

// File: tb/tb_qws_ready_gen.sv
module tb_qws_ready_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic        mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
    logic [15:0] addr = 16'h0;
    logic        ready;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    qws_ready_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .addr(addr), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // kind: 0 mem_rd, 1 mem_wr, 2 io_rd, 3 io_wr, 4 mem_rd+io_rd
    task automatic access(input int kind, input logic [15:0] a, input int exp, input string req);
        int got;
        int extra;
        got = -1;
        extra = 0;
        @(negedge clk);
        addr = a;
        mem_rd = (kind == 0 || kind == 4);
        mem_wr = (kind == 1);
        io_rd  = (kind == 2 || kind == 4);
        io_wr  = (kind == 3);
        for (int k = 0; k <= exp + 20; k++) begin
            @(negedge clk);
            if (ready) begin
                got = k;
                break;
            end
        end
        chk(got == exp, req, got, exp);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            if (ready) extra++;
        end
        chk(extra == 0, "R5", extra, 0);
        mem_rd = 0; mem_wr = 0; io_rd = 0; io_wr = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int fld(input logic [15:0] r, input logic [15:0] a);
        return int'((r >> (4 * a[15:14])) & 16'hF);
    endfunction

    function automatic bit in_win(input logic [15:0] a);
        return a[14:8] == 7'd0;
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] mpat [2];
        logic [15:0] offs [3];
        logic [15:0] ioa [11];
        logic [15:0] iopat;
        int e;
        mpat[0] = 16'h3A50; mpat[1] = 16'h09C1;
        offs[0] = 16'h0000; offs[1] = 16'h2A5A; offs[2] = 16'h3FFF;
        ioa[0] = 16'h0000; ioa[1] = 16'h00FF; ioa[2] = 16'h8000; ioa[3] = 16'h80FF;
        ioa[4] = 16'h0100; ioa[5] = 16'h4000; ioa[6] = 16'h7FFF; ioa[7] = 16'h9000;
        ioa[8] = 16'hC0FF; ioa[9] = 16'hFFFF; ioa[10] = 16'h8100;
        iopat = 16'h7263;

        repeat (4) @(negedge clk);
        chk(ready == 1'b0, "R1", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0, "R1", ready, 0);

        // R1: memory waits default to 15 everywhere
        access(0, 16'h1234, 15, "R1");
        access(1, 16'hC000, 15, "R1");

        // R2: memory quadrant sweep under two patterns
        foreach (mpat[p]) begin
            wr_cfg(2'd1, mpat[p]);
            for (int q = 0; q < 4; q++) begin
                foreach (offs[o]) begin
                    logic [15:0] a;
                    a = 16'(q * 16'h4000) | offs[o];
                    access(o % 2, a, fld(mpat[p], a), "R2");
                end
            end
        end

        // R3 / R4: I/O sweep with extend off and on
        wr_cfg(2'd2, iopat);
        for (int x = 0; x < 2; x++) begin
            wr_cfg(2'd0, x ? 16'h0100 : 16'h0000);
            foreach (ioa[i]) begin
                if (in_win(ioa[i])) begin
                    access(2 + (i % 2), ioa[i], fld(iopat, ioa[i]), "R3");
                end else begin
                    e = x ? fld(iopat, ioa[i]) : 0;
                    access(2 + (i % 2), ioa[i], e, "R4");
                end
            end
        end

        // R11: select 3 writes leave memory waits (09C1) untouched
        wr_cfg(2'd3, 16'h0000);
        access(0, 16'h4000, 12, "R11");
        access(0, 16'h8000, 9, "R11");

        // R10: memory field wins over I/O field
        access(4, 16'h4000, 12, "R10");
        access(4, 16'h0010, 1, "R10");

        // R9: dropped access gives no pulse; next access normal
        begin
            int seen;
            seen = 0;
            @(negedge clk);
            addr = 16'h8000; mem_rd = 1'b1;
            repeat (3) @(negedge clk);
            mem_rd = 1'b0;
            for (int k = 0; k < 15; k++) begin
                @(negedge clk);
                if (ready) seen++;
            end
            chk(seen == 0, "R9", seen, 0);
            access(0, 16'h8000, 9, "R9");
        end

        // R6: long memory mode
        wr_cfg(2'd1, 16'h5432);
        wr_cfg(2'd0, 16'h0401);
        access(0, 16'h0123, 2 * 1000, "R6");
        access(0, 16'h4000, 3, "R6");
        access(1, 16'hC000, 5, "R6");
        wr_cfg(2'd1, 16'h5431);
        wr_cfg(2'd0, 16'h0402);
        access(0, 16'h3FFF, 1 * 2 * 1000, "R6");
        // R8: zero frequency counts as 1 MHz, zero field gives no wait
        wr_cfg(2'd0, 16'h0400);
        access(0, 16'h0000, 1000, "R8");
        wr_cfg(2'd1, 16'h5430);
        access(0, 16'h0000, 0, "R8");

        // R7: long I/O mode in windows only
        wr_cfg(2'd2, 16'h7261);
        wr_cfg(2'd0, 16'h0203);
        access(2, 16'h0010, 1 * 3 * 1000, "R7");
        access(3, 16'h8010, 2 * 3 * 1000, "R7");
        access(2, 16'h4000, 0, "R7");
        access(2, 16'h0100, 0, "R7");
        access(0, 16'h4000, 3, "R7");
        wr_cfg(2'd0, 16'h0303);
        access(2, 16'h0100, 1, "R7");
        access(2, 16'hC000, 7, "R7");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule